// File: doc/BRIEF.md
# Lockable Timeout Watchdog

This block guards a processor against a hung program. A 16-bit tick counter runs from a selectable prescaled clock. The counter is split into a low byte that rolls over freely and a high byte that is compared against a compare byte. Software refreshes the guard by pulsing `kick`. The compare byte then becomes the current high count plus an 8-bit offset register. If software does not refresh in time, the high byte reaches the compare byte. When the low byte then rolls over from 0xFF, the block raises a one-cycle reset request.

Software configures the block through a 6-bit control register and an offset register, and both can be read back. The block leaves reset already armed at divide-by-12 with a zero offset, so an unattended system resets itself after 3072 clock cycles. A lock bit keeps the guard running until the next reset. The prescale select and the idle-suspend bit are frozen whenever the guard runs. When idle-suspend is set, the count pauses while the processor reports that it is idle.

The controller has five states. It sits in RUN_ST out of reset. The transitions are:
- OFF_ST→RUN_ST when enabled.
- RUN_ST→OFF_ST when disabled.
- RUN_ST→HOLD_ST when the idle pause applies.
- HOLD_ST→RUN_ST when the pause ends.
- HOLD_ST→OFF_ST when disabled.
- RUN_ST→BITE_ST on expiry.
- BITE_ST→SPENT_ST unconditionally.

SPENT_ST holds until the system resets.

Top module: `wdt_top`

## Requirements
- R1: After reset the control readback is 6'b000001 and the offset readback is 0. The control fields are: bit 0 enable, bit 1 lock, bit 2 idle-suspend, bits 5:3 prescale select.
- R2: With the reset defaults and no writes, the reset request appears 3072 clock cycles after reset is released.
- R3: The counter starts at zero and the compare byte holds c. The request then follows after 256·(c+1) ticks. In general, a refresh with offset k and low count L gives 256·k + (256 − L) ticks.
- R4: A `kick` pulse loads the compare byte with the current high count plus the offset register, so a refresh can postpone the request.
- R5: Setting the lock bit runs the guard even when enable is 0. The lock bit stays set until reset, and writes that clear enable are ignored while it is set.
- R6: While the guard runs (enable or lock set), writes do not change the prescale select or the idle-suspend bit.
- R7: While unlocked, clearing enable stops the guard, and no request is issued.
- R8: With idle-suspend set, counting pauses while `cpu_idle` is high. With idle-suspend clear, `cpu_idle` has no effect.
- R9: The prescale select codes are: 0 gives one tick per 12 cycles, 1 gives one tick per 4 cycles, 2 gives one tick per cycle, and any other code behaves as 0.
- R10: The reset request lasts exactly one cycle, and no further request follows until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data (fields as in R1) |
| off_we | input | 1 | Offset register write strobe |
| off_wdata | input | 8 | Offset write data |
| kick | input | 1 | Refresh strobe |
| cpu_idle | input | 1 | Processor idle indication |
| rd_ctl | output | 6 | Control register readback |
| rd_off | output | 8 | Offset register readback |
| wdt_rst | output | 1 | One-cycle reset request |

## Verification
The first edge after a control write updates the register. One edge later the controller enters RUN_ST. Tick k is then registered one edge after that, and the request is visible after the edge that registers the 256·(c+1)-th tick. Counting the write edge as 1, an enable at one tick per cycle therefore yields the request at edge 256·(c+1)+2, and 1026 or 3074 at the slower prescales. Out of reset the count starts at the first edge, giving 3072. The bench counts edges itself and samples `wdt_rst` at the following falling edge. It drives `kick`, `cpu_idle` and second writes at falling edges indexed by the same count, so every expected edge number is fixed in advance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        OFF_ST,
        RUN_ST,
        HOLD_ST,
        BITE_ST,
        SPENT_ST
    } wdt_state_e;

    typedef struct packed {
        logic [2:0] psel;
        logic       idle_sus;
        logic       lock;
        logic       en;
    } wdt_ctl_t;

    localparam logic [2:0] PSEL_SLOW = 3'd0;
    localparam logic [2:0] PSEL_MID  = 3'd1;
    localparam logic [2:0] PSEL_FULL = 3'd2;

    localparam wdt_ctl_t CTL_RESET = '{psel: PSEL_SLOW, idle_sus: 1'b0,
                                       lock: 1'b0, en: 1'b1};

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  wdt_ctl_t         ctl_wdata,
    input  logic             off_we,
    input  logic [OFF_W-1:0] off_wdata,
    output wdt_ctl_t         ctl_q,
    output logic [OFF_W-1:0] off_q,
    output logic             active
);

    assign active = ctl_q.en | ctl_q.lock;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            off_q <= '0;
        end else begin
            if (ctl_we) begin
                // lock is sticky; enable can only be raised while locked
                ctl_q.lock <= ctl_q.lock | ctl_wdata.lock;
                ctl_q.en   <= ctl_q.lock ? (ctl_q.en | ctl_wdata.en) : ctl_wdata.en;
                if (!active) begin
                    ctl_q.psel     <= ctl_wdata.psel;
                    ctl_q.idle_sus <= ctl_wdata.idle_sus;
                end
            end
            if (off_we) begin
                off_q <= off_wdata;
            end
        end
    end

endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_MID  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] psel,
    output logic       tick
);

    localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_MID  = PW'(DIV_MID - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    always_comb begin
        unique case (psel)
            PSEL_MID:  lim = LIM_MID;
            PSEL_FULL: lim = '0;
            default:   lim = LIM_SLOW;
        endcase
    end

    assign tick = run && (pre_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         idle_sus,
    input  logic         cpu_idle,
    input  logic         tick,
    input  logic         kick,
    input  logic [W-1:0] off,
    output logic         run,
    output logic         bite
);

    wdt_state_e    st_q, st_d;
    logic [2*W-1:0] cnt_q;
    logic [W-1:0]   cmp_q;
    logic           expire;
    logic           pause;

    assign pause  = idle_sus && cpu_idle;
    assign expire = run && tick && (&cnt_q[W-1:0]) && (cnt_q[2*W-1:W] == cmp_q);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OFF_ST:   if (active) st_d = RUN_ST;
            RUN_ST: begin
                if (!active)     st_d = OFF_ST;
                else if (expire) st_d = BITE_ST;
                else if (pause)  st_d = HOLD_ST;
            end
            HOLD_ST: begin
                if (!active)     st_d = OFF_ST;
                else if (!pause) st_d = RUN_ST;
            end
            BITE_ST:  st_d = SPENT_ST;
            SPENT_ST: st_d = SPENT_ST;
            default:  st_d = OFF_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RUN_ST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        run  = (st_q == RUN_ST);
        bite = (st_q == BITE_ST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            if (run && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (kick) begin
                cmp_q <= cnt_q[2*W-1:W] + off;
            end
        end
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DIV_SLOW = 12,
    parameter int DIV_MID  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [5:0]       ctl_wdata,
    input  logic             off_we,
    input  logic [CNT_W-1:0] off_wdata,
    input  logic             kick,
    input  logic             cpu_idle,
    output logic [5:0]       rd_ctl,
    output logic [CNT_W-1:0] rd_off,
    output logic             wdt_rst
);

    wdt_ctl_t ctl_q;
    logic     active;
    logic     run;
    logic     tick;

    wdt_regs #(.OFF_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (wdt_ctl_t'(ctl_wdata)),
        .off_we    (off_we),
        .off_wdata (off_wdata),
        .ctl_q     (ctl_q),
        .off_q     (rd_off),
        .active    (active)
    );

    wdt_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .psel  (ctl_q.psel),
        .tick  (tick)
    );

    wdt_core #(.W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .idle_sus (ctl_q.idle_sus),
        .cpu_idle (cpu_idle),
        .tick     (tick),
        .kick     (kick),
        .off      (rd_off),
        .run      (run),
        .bite     (wdt_rst)
    );

    assign rd_ctl = ctl_q;

endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] ctl,
    input logic       wdt_rst
);

    logic act;
    assign act = ctl[0] | ctl[1];

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[1] |=> ctl[1]);

    p_locked_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[1] && ctl[0]) |=> ctl[0]);

    p_frozen_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> $stable(ctl[5:2]));

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && $past(!act)) |-> !wdt_rst);

endmodule

bind wdt_top wdt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (rd_ctl),
    .wdt_rst (wdt_rst)
);

// File: tb/sim_wdt_top.sv
module sim_wdt_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       off_we = 1'b0;
    logic [7:0] off_wdata = '0;
    logic       kick = 1'b0;
    logic       cpu_idle = 1'b0;
    logic [5:0] rd_ctl;
    logic [7:0] rd_off;
    logic       wdt_rst;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .off_we(off_we), .off_wdata(off_wdata), .kick(kick), .cpu_idle(cpu_idle),
        .rd_ctl(rd_ctl), .rd_off(rd_off), .wdt_rst(wdt_rst)
    );

    // control encoding: {psel[2:0], idle_sus, lock, en}
    function automatic logic [5:0] cw(input logic [2:0] ps, input logic ids,
                                      input logic lk, input logic en);
        return {ps, ids, lk, en};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ctl_we = 0; off_we = 0; kick = 0; cpu_idle = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_ctl(input logic [5:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_off(input logic [7:0] d);
        off_we = 1'b1; off_wdata = d;
        @(negedge clk);
        off_we = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
    endtask

    // reset, then disable so the count stays at zero
    task automatic prep(input logic [7:0] off);
        do_reset();
        wr_ctl(cw(3'd0, 0, 0, 0));
        wr_off(off);
        do_kick();
    endtask

    // counts edges from the optional write edge (edge 1) until wdt_rst is seen
    task automatic run_until(input logic do_wr, input logic [5:0] wd, input int limit,
                             input int kick_at, input int is, input int il,
                             input int w2_at, input logic [5:0] wd2, output int n);
        if (do_wr) begin
            ctl_we = 1'b1; ctl_wdata = wd;
        end
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            ctl_we = 1'b0;
            kick = 1'b0;
            if (wdt_rst) begin
                cpu_idle = 1'b0;
                return;
            end
            cpu_idle = (n >= is) && (n < is + il);
            if (n == kick_at) kick = 1'b1;
            if (n == w2_at) begin
                ctl_we = 1'b1; ctl_wdata = wd2;
            end
        end
        cpu_idle = 1'b0;
        n = -1;
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        check("R1 ctl", int'(rd_ctl), 1);
        check("R1 off", int'(rd_off), 0);
        check("R1 no request", int'(wdt_rst), 0);
    endtask

    task automatic t_default_timeout();
        int n;
        do_reset();
        run_until(0, '0, 4000, -1, 0, 0, -1, '0, n);
        check("R2 default timeout", n, 3072);
    endtask

    task automatic t_offsets();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, -1, 0, 0, -1, '0, n);
        check("R3 offset 0", n, 258);
        prep(8'd2);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, -1, 0, 0, -1, '0, n);
        check("R3 offset 2", n, 770);
    endtask

    task automatic t_kick();
        int n;
        prep(8'd0);
        wr_off(8'd1);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, 100, 0, 0, -1, '0, n);
        check("R4 refresh postpones", n, 514);
    endtask

    task automatic t_prescale();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd1, 0, 0, 1), 3000, -1, 0, 0, -1, '0, n);
        check("R9 code1 div4", n, 1026);
        prep(8'd0);
        run_until(1, cw(3'd0, 0, 0, 1), 5000, -1, 0, 0, -1, '0, n);
        check("R9 code0 div12", n, 3074);
        prep(8'd0);
        run_until(1, cw(3'd5, 0, 0, 1), 5000, -1, 0, 0, -1, '0, n);
        check("R9 code5 as div12", n, 3074);
    endtask

    task automatic t_lock();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 1, 1), 2000, -1, 0, 0, 5, cw(3'd2, 0, 0, 0), n);
        check("R5 clear ignored when locked", n, 258);
        check("R5 readback en+lock", int'(rd_ctl[1:0]), 3);
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 1, 0), 2000, -1, 0, 0, -1, '0, n);
        check("R5 lock alone runs", n, 258);
        check("R5 readback lock only", int'(rd_ctl[1:0]), 2);
    endtask

    task automatic t_freeze();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, -1, 10, 30, 3, cw(3'd0, 1, 0, 1), n);
        check("R6 frozen fields timing", n, 258);
        check("R6 psel kept", int'(rd_ctl[5:3]), 2);
        check("R6 idle_sus kept", int'(rd_ctl[2]), 0);
    endtask

    task automatic t_disable();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 0, 1), 700, -1, 0, 0, 5, cw(3'd2, 0, 0, 0), n);
        check("R7 disabled no request", n, -1);
        check("R7 readback en", int'(rd_ctl[0]), 0);
    endtask

    task automatic t_idle();
        int n;
        prep(8'd0);
        run_until(1, cw(3'd2, 1, 0, 1), 2000, -1, 10, 30, -1, '0, n);
        check("R8 idle pauses", n, 288);
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, -1, 10, 30, -1, '0, n);
        check("R8 idle ignored", n, 258);
    endtask

    task automatic t_pulse();
        int n;
        int seen;
        prep(8'd0);
        run_until(1, cw(3'd2, 0, 0, 1), 2000, -1, 0, 0, -1, '0, n);
        check("R10 request seen", n, 258);
        seen = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (wdt_rst) seen++;
        end
        check("R10 single pulse", seen, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_default_timeout();
        t_offsets();
        t_kick();
        t_prescale();
        t_lock();
        t_freeze();
        t_disable();
        t_idle();
        t_pulse();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule